// File: doc/BRIEF.md
# Edge-Clocked Event Counter with Trigger Selection

This block is an up-counter whose count can follow edges on an external pin instead of the system clock. Either of two external inputs is brought into the clock domain through a two-stage synchronizer and routed onto a single trigger channel by a mapping field. The channel then passes through a digital filter of programmable length and an edge detector with selectable polarity. When the trigger source select names that channel, each qualified edge becomes a trigger event.

In the external-clock slave mode, each trigger event advances the counter by one. In any other mode, the counter advances on every system clock. Both cases require the enable bit to be set. A sticky flag records trigger events until it is cleared. When the counter rolls over from all ones to zero, a one-cycle update pulse accompanies the step.

All control fields are plain inputs, meant to be driven from a register bank outside the block.

Top module: `edge_count_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `cnt` is 0, `trig_flag` is 0 and `upd` is 0.
- R2: Take filter setting 0 and the external-clock setup of R3. An input rise driven between clock edges first shows in `cnt` after the fourth following rising clock edge, and not after the third.
- R3: Take `mode_sel`=3'b111, `trig_sel`=3'b110, `ch2_map`=2'b01, `edge_pol`=0 and `cen`=1. Each rising edge on `tin[1]` adds exactly one to `cnt`.
- R4: Every qualified trigger event sets `trig_flag`, whatever the value of `cen`.
- R5: `trig_flag` stays at 1 until `flag_clr` is high for a cycle with no trigger event in that same cycle. If a trigger event and a clear arrive together, the flag stays set.
- R6: With `cen`=0 the counter holds its value in every mode.
- R7: For a nonzero `flt_sel` value f, the filtered level changes only after 2*f consecutive synchronized samples that differ from it. A pulse shorter than that produces no count. A longer pulse produces exactly one count.
- R8: With `edge_pol`=1, only falling edges of the selected input are counted. The rise that comes before a fall produces no count.
- R9: `ch2_map`=2'b01 routes `tin[1]` onto the trigger channel and 2'b10 routes `tin[0]`. The values 2'b00 and 2'b11 route neither input, so no events occur.
- R10: In mode 3'b111, any `trig_sel` value other than 3'b110 gives no trigger events. `cnt` and `trig_flag` then stay unchanged.
- R11: With `mode_sel` different from 3'b111 and `cen`=1, `cnt` advances by one on every clock.
- R12: The step from all ones wraps `cnt` to 0. `upd` is high only in the cycle before that step, so each wrap gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tin | input | 2 | Asynchronous external inputs |
| ch2_map | input | 2 | Trigger channel input mapping |
| flt_sel | input | 4 | Filter length setting (0 = none) |
| edge_pol | input | 1 | 0 = rising, 1 = falling edge |
| mode_sel | input | 3 | Slave mode; 3'b111 = external clock |
| trig_sel | input | 3 | Trigger source; 3'b110 = filtered channel |
| cen | input | 1 | Counter enable |
| flag_clr | input | 1 | One-cycle clear of the trigger flag |
| cnt | output | W | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |
| upd | output | 1 | Rollover pulse |

## Verification
The assertions assume that the configuration fields are not changed while the selected input is active. The filter run length and the edge register are therefore never caught half-way. The stimulus changes mapping, polarity, filter and mode only while both inputs are low and the pipeline has settled. Every pulse is followed by a long idle period, so each expectation is compared against a quiet design. The latency check is the one exception: it samples cycle by cycle right after an edge.

// File: rtl/edge_count_timer.sv
module edge_count_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   tin,
  input  logic [1:0]   ch2_map,
  input  logic [3:0]   flt_sel,
  input  logic         edge_pol,
  input  logic [2:0]   mode_sel,
  input  logic [2:0]   trig_sel,
  input  logic         cen,
  input  logic         flag_clr,
  output logic [W-1:0] cnt,
  output logic         trig_flag,
  output logic         upd
);
  localparam logic [2:0] MODE_EXT  = 3'b111;
  localparam logic [2:0] TSEL_CH   = 3'b110;
  localparam logic [1:0] MAP_OWN   = 2'b01;
  localparam logic [1:0] MAP_CROSS = 2'b10;
  localparam int         RW        = 5;

  logic [1:0]    s0, s1;
  logic          src, flt, flt_d;
  logic [RW-1:0] run_len;
  logic [RW-1:0] need;
  logic          edge_raw, trig, inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0 <= '0;
      s1 <= '0;
    end else begin
      s0 <= tin;
      s1 <= s0;
    end
  end

  always_comb begin
    case (ch2_map)
      MAP_OWN:   src = s1[1];
      MAP_CROSS: src = s1[0];
      default:   src = 1'b0;
    endcase
  end

  assign need = {flt_sel, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt     <= 1'b0;
      flt_d   <= 1'b0;
      run_len <= '0;
    end else begin
      flt_d <= flt;
      if (flt_sel == 4'd0) begin
        flt     <= src;
        run_len <= '0;
      end else if (src == flt) begin
        run_len <= '0;
      end else if (run_len == need - RW'(1)) begin
        flt     <= src;
        run_len <= '0;
      end else begin
        run_len <= run_len + RW'(1);
      end
    end
  end

  assign edge_raw = edge_pol ? (flt_d & ~flt) : (flt & ~flt_d);
  assign trig     = edge_raw && (trig_sel == TSEL_CH);
  assign inc      = cen && ((mode_sel == MODE_EXT) ? trig : 1'b1);
  assign upd      = inc && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      trig_flag <= 1'b0;
    end else begin
      if (inc) cnt <= cnt + W'(1);
      if (trig) trig_flag <= 1'b1;
      else if (flag_clr) trig_flag <= 1'b0;
    end
  end

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (W'(cnt - $past(cnt)) == W'(1)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> $stable(cnt));

  // R11
  int_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && mode_sel != MODE_EXT) |=> (W'(cnt - $past(cnt)) == W'(1)));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> trig_flag);

  // R5
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_flag) |-> $past(flag_clr));

  // R12
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == '0));
endmodule

// File: tb/tb_edge_count_timer.sv
module tb_edge_count_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tin = '0;
  logic [1:0]  ch2_map = 2'b01;
  logic [3:0]  flt_sel = '0;
  logic        edge_pol = 1'b0;
  logic [2:0]  mode_sel = 3'b111;
  logic [2:0]  trig_sel = 3'b110;
  logic        cen = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cnt;
  logic        trig_flag, upd;

  typedef struct {
    logic [15:0] c;
    logic        f;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails = 0;
  int          upd_seen = 0;
  logic [15:0] exp_cnt = '0;
  logic        exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_count_timer dut (
    .clk(clk), .rst_n(rst_n), .tin(tin), .ch2_map(ch2_map), .flt_sel(flt_sel),
    .edge_pol(edge_pol), .mode_sel(mode_sel), .trig_sel(trig_sel), .cen(cen),
    .flag_clr(flag_clr), .cnt(cnt), .trig_flag(trig_flag), .upd(upd));

  initial forever begin
    @(negedge clk);
    #1;
    if (upd === 1'b1) upd_seen++;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cnt !== e.c || trig_flag !== e.f) begin
        fails++;
        $display("FAIL %s: cnt=%0h flag=%0b expected cnt=%0h flag=%0b",
                 e.tag, cnt, trig_flag, e.c, e.f);
      end
    end
  end

  task automatic expect_now(input string tag);
    q.push_back('{exp_cnt, exp_flag, tag});
    @(negedge clk);
  endtask

  task automatic pulse(input int b, input int hi);
    @(negedge clk);
    tin[b] = 1'b1;
    repeat (hi) @(negedge clk);
    tin[b] = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_flag = 1'b0;
  endtask

  task automatic scalar_check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 after reset");
    scalar_check("R1 upd low", int'(upd), 0);
    cen = 1'b1;

    // R2 latency: rise driven now, visible after 4th posedge
    tin[1] = 1'b1;
    repeat (3) @(negedge clk);
    q.push_back('{exp_cnt, exp_flag, "R2 not after 3 edges"});
    @(negedge clk);
    exp_cnt++; exp_flag = 1'b1;
    q.push_back('{exp_cnt, exp_flag, "R2 after 4 edges"});
    @(negedge clk);
    tin[1] = 1'b0;
    repeat (20) @(negedge clk);
    expect_now("R3 first edge counted, R4 flag set");

    clear_flag();
    expect_now("R5 flag cleared");
    repeat (5) @(negedge clk);
    expect_now("R5 flag stays cleared");

    for (int i = 0; i < 3; i++) begin
      pulse(1, 1 + i);
      exp_cnt++; exp_flag = 1'b1;
    end
    expect_now("R3 three more edges");

    clear_flag();
    cen = 1'b0;
    pulse(1, 3);
    exp_flag = 1'b1;
    expect_now("R6 count held, R4 flag set while disabled");
    cen = 1'b1;
    clear_flag();

    flt_sel = 4'd3;
    pulse(1, 5);
    expect_now("R7 short pulse filtered");
    pulse(1, 8);
    exp_cnt++; exp_flag = 1'b1;
    expect_now("R7 long pulse counted once");
    flt_sel = 4'd0;
    clear_flag();

    edge_pol = 1'b1;
    @(negedge clk);
    tin[1] = 1'b1;
    repeat (20) @(negedge clk);
    expect_now("R8 rise ignored with falling polarity");
    tin[1] = 1'b0;
    repeat (20) @(negedge clk);
    exp_cnt++; exp_flag = 1'b1;
    expect_now("R8 fall counted");
    edge_pol = 1'b0;
    clear_flag();

    ch2_map = 2'b10;
    pulse(1, 3);
    expect_now("R9 cross map ignores tin1");
    pulse(0, 3);
    exp_cnt++; exp_flag = 1'b1;
    expect_now("R9 cross map counts tin0");
    clear_flag();
    ch2_map = 2'b00;
    pulse(0, 3);
    pulse(1, 3);
    expect_now("R9 map 00 routes nothing");
    ch2_map = 2'b01;

    trig_sel = 3'b101;
    pulse(1, 3);
    expect_now("R10 other trigger source ignored");
    trig_sel = 3'b110;

    cen = 1'b0;
    mode_sel = 3'b000;
    @(negedge clk);
    cen = 1'b1;
    repeat (10) @(negedge clk);
    cen = 1'b0;
    exp_cnt = exp_cnt + 16'd10;
    expect_now("R11 internal clock counts every cycle");

    upd_seen = 0;
    @(negedge clk);
    cen = 1'b1;
    repeat (int'(17'h10000 - {1'b0, exp_cnt})) @(negedge clk);
    cen = 1'b0;
    exp_cnt = '0;
    expect_now("R12 wrapped to zero");
    @(negedge clk);
    scalar_check("R12 single update pulse", upd_seen, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule